// File: doc/BRIEF.md
# Transactional Line Cache

This block is a small, fully associative cache that sits beside the ordinary data cache. It holds every line touched by the single hardware transaction a processor may have in flight. Three transactional accesses reach it on one request port: a plain transactional load, a load that declares an intent to write, and a transactional store. The same port also carries three transaction commands: commit, abort and validate. Each request completes in one cycle and its response appears on the registered response outputs one cycle later.

Every entry carries a transactional tag (empty, normal, discard-on-commit or discard-on-abort) next to a coherence state (invalid, shared or modified). The first speculative write to a line creates a pair of entries. The discard-on-commit entry keeps the old value and the discard-on-abort entry holds the new value. Commit and abort then resolve every speculative entry in the same single cycle. A snoop port delivers remote read and remote write probes by line address. A probe that conflicts with the transaction's read or write set sets a sticky aborted flag, so the next commit fails and rolls back instead. Lines fill from backing memory through a combinational read port. A dirty committed line that is evicted leaves through a one-line write-back port.

Top module: `txn_line_cache`

## Requirements
- R1: Reset empties every entry and clears the aborted flag. While reset is held, `resp_valid`, `overflow` and `wb_valid` are 0, and after reset a load returns the backing-memory value even for lines that were cached before.
- R2: Every request cycle gives `resp_valid`=1 one cycle later, and idle cycles give none. A load that misses fills from `mem_rdata` at `mem_raddr`=`req_addr`. A load that hits returns the cached value. Both set `resp_ok`=1.
- R3: A store writes only inside the cache. Later loads of that line return the stored value, and no write-back is issued for it.
- R4: Commit with no conflict returns `resp_ok`=1. Discard-on-commit entries become empty and discard-on-abort entries become normal, modified lines, so stored data stays visible from the cache without a memory write.
- R5: Abort always returns `resp_ok`=1. It turns discard-on-abort entries into empty entries and discard-on-commit entries back into normal entries, so the value before the store is restored.
- R6: A remote read probe that hits a write-set line (one made speculative by a store or exclusive load) makes the next commit return `resp_ok`=0 and perform the abort action.
- R7: A remote write probe that hits a read-set line aborts the transaction. A remote read probe that hits a line only in the read set does not.
- R8: Validate (op code 5) returns `resp_ok`=1 while the transaction is not aborted and 0 once it is. Commit (op code 3) and abort (op code 4) clear the aborted flag.
- R9: A transactional access that finds no usable entry raises `overflow` together with `resp_valid` and `resp_ok`=0, and it sets the aborted flag. Read-set lines and speculative lines are never evicted.
- R10: Victims are chosen from empty entries first, then clean normal lines, then dirty normal lines, lowest entry index first within each group, and entries fill from index 0 upward. Evicting a dirty normal line gives one `wb_valid` pulse, with that line's address and data, in the response cycle.
- R11: A conflicting probe in the same cycle as a commit makes that commit fail.
- R12: An exclusive load (op code 1) returns the line's data and places the line in the write set, so a remote read of it aborts the transaction.
- R13: An access that would have to evict two dirty lines in one cycle overflows instead, and it issues no write-back.

Op codes on `req_op`: 0 load, 1 exclusive load, 2 store, 3 commit, 4 abort, 5 validate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request op code |
| req_addr | input | ADDR_W | Line address of an access |
| req_wdata | input | DATA_W | Store data |
| mem_raddr | output | ADDR_W | Backing-memory read address |
| mem_rdata | input | DATA_W | Backing-memory read data, same cycle |
| snp_valid | input | 1 | Remote probe present |
| snp_is_write | input | 1 | 1 = remote write probe, 0 = remote read probe |
| snp_addr | input | ADDR_W | Probe line address |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_ok | output | 1 | Success / transaction still live |
| resp_data | output | DATA_W | Load data |
| overflow | output | 1 | Access found no usable entry |
| wb_valid | output | 1 | Write-back of an evicted dirty line |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |

## Verification
Every result (response, overflow and write-back) is registered once, so it is due exactly one clock edge after the request that caused it. The bench drives a request on a falling edge and samples the outputs on the next falling edge, after the single register stage has updated. Probe effects show up either in the same-cycle command's response (validate or commit) or in a later validate, and never earlier. The backing memory in the bench takes write-backs at the sample point, before the next request reads it.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        TAG_EMPTY   = 2'd0,
        TAG_NORMAL  = 2'd1,
        TAG_XCOMMIT = 2'd2,
        TAG_XABORT  = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        MSI_I = 2'd0,
        MSI_S = 2'd1,
        MSI_M = 2'd2
    } msi_e;

    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_LOAD_EXCL = 3'd1,
        OP_STORE     = 3'd2,
        OP_COMMIT    = 3'd3,
        OP_ABORT     = 3'd4,
        OP_VALIDATE  = 3'd5
    } op_e;
endpackage

// File: rtl/txc_lookup.sv
module txc_lookup
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 2
) (
    input  tag_e [ENTRIES-1:0]             tags,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]              key,
    output logic                           xa_hit,
    output logic [IDX_W-1:0]               xa_idx,
    output logic                           nm_hit,
    output logic [IDX_W-1:0]               nm_idx
);
    logic [ENTRIES-1:0] xa_m;
    logic [ENTRIES-1:0] nm_m;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign xa_m[g] = (tags[g] == TAG_XABORT) && (addrs[g] == key);
        assign nm_m[g] = (tags[g] == TAG_NORMAL) && (addrs[g] == key);
    end

    always_comb begin
        xa_hit = 1'b0;
        xa_idx = '0;
        nm_hit = 1'b0;
        nm_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (xa_m[i] && !xa_hit) begin
                xa_hit = 1'b1;
                xa_idx = IDX_W'(i);
            end
            if (nm_m[i] && !nm_hit) begin
                nm_hit = 1'b1;
                nm_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/txc_victim.sv
module txc_victim
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  tag_e [ENTRIES-1:0] tags,
    input  logic [ENTRIES-1:0] rd,
    input  logic [ENTRIES-1:0] dirty,
    input  logic               excl_valid,
    input  logic [IDX_W-1:0]   excl_idx,
    output logic               a_found,
    output logic [IDX_W-1:0]   a_idx,
    output logic               a_dirty,
    output logic               b_found,
    output logic [IDX_W-1:0]   b_idx,
    output logic               b_dirty
);
    // class 0: empty, class 1: clean normal, class 2: dirty normal
    logic [2:0][ENTRIES-1:0] cls_m;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cls
        logic usable;
        assign usable      = !(excl_valid && (excl_idx == IDX_W'(g)));
        assign cls_m[0][g] = usable && (tags[g] == TAG_EMPTY);
        assign cls_m[1][g] = usable && (tags[g] == TAG_NORMAL) && !rd[g] && !dirty[g];
        assign cls_m[2][g] = usable && (tags[g] == TAG_NORMAL) && !rd[g] && dirty[g];
    end

    always_comb begin
        a_found = 1'b0;
        a_idx   = '0;
        a_dirty = 1'b0;
        b_found = 1'b0;
        b_idx   = '0;
        b_dirty = 1'b0;
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (cls_m[c][i]) begin
                    if (!a_found) begin
                        a_found = 1'b1;
                        a_idx   = IDX_W'(i);
                        a_dirty = (c == 2);
                    end else if (!b_found) begin
                        b_found = 1'b1;
                        b_idx   = IDX_W'(i);
                        b_dirty = (c == 2);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/txn_line_cache.sv
module txn_line_cache
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snp_valid,
    input  logic              snp_is_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [DATA_W-1:0] resp_data,
    output logic              overflow,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        tag_e              tag;
        msi_e              msi;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        line_t [ENTRIES-1:0] line;
        logic                aborted;
        logic                resp_valid;
        logic                resp_ok;
        logic [DATA_W-1:0]   resp_data;
        logic                overflow;
        logic                wb_valid;
        logic [ADDR_W-1:0]   wb_addr;
        logic [DATA_W-1:0]   wb_data;
    } state_t;

    state_t st_q, st_d;

    tag_e [ENTRIES-1:0]             tags_v;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_v;
    logic [ENTRIES-1:0]             rd_v;
    logic [ENTRIES-1:0]             dirty_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign tags_v[g]  = st_q.line[g].tag;
        assign addr_v[g]  = st_q.line[g].addr;
        assign rd_v[g]    = st_q.line[g].rd;
        assign dirty_v[g] = (st_q.line[g].msi == MSI_M);
    end

    logic             r_xa_hit, r_nm_hit, s_xa_hit, s_nm_hit;
    logic [IDX_W-1:0] r_xa_idx, r_nm_idx, s_xa_idx, s_nm_idx;

    txc_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req_lookup (
        .tags(tags_v), .addrs(addr_v), .key(req_addr),
        .xa_hit(r_xa_hit), .xa_idx(r_xa_idx), .nm_hit(r_nm_hit), .nm_idx(r_nm_idx)
    );

    txc_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snp_lookup (
        .tags(tags_v), .addrs(addr_v), .key(snp_addr),
        .xa_hit(s_xa_hit), .xa_idx(s_xa_idx), .nm_hit(s_nm_hit), .nm_idx(s_nm_idx)
    );

    logic             v_a_found, v_a_dirty, v_b_found, v_b_dirty;
    logic [IDX_W-1:0] v_a_idx, v_b_idx;

    txc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .tags(tags_v), .rd(rd_v), .dirty(dirty_v),
        .excl_valid(r_nm_hit), .excl_idx(r_nm_idx),
        .a_found(v_a_found), .a_idx(v_a_idx), .a_dirty(v_a_dirty),
        .b_found(v_b_found), .b_idx(v_b_idx), .b_dirty(v_b_dirty)
    );

    op_e  op;
    logic wr_set_probe, rd_set_probe, conflict_now, abort_now;

    assign op        = op_e'(req_op);
    assign mem_raddr = req_addr;

    // write set: a discard-on-abort entry at the probe address (its partner is implied)
    assign wr_set_probe = s_xa_hit && (st_q.line[s_xa_idx].tag == TAG_XABORT);
    assign rd_set_probe = s_nm_hit && st_q.line[s_nm_idx].rd;
    assign conflict_now = snp_valid && (wr_set_probe || (snp_is_write && rd_set_probe));
    assign abort_now    = st_q.aborted || conflict_now;

    always_comb begin
        logic              resolve, commit_ok, spill;
        logic [IDX_W-1:0]  spill_idx;
        logic [DATA_W-1:0] old_val;

        st_d            = st_q;
        st_d.resp_valid = req_valid;
        st_d.resp_ok    = 1'b0;
        st_d.resp_data  = '0;
        st_d.overflow   = 1'b0;
        st_d.wb_valid   = 1'b0;
        resolve         = 1'b0;
        commit_ok       = 1'b0;
        spill           = 1'b0;
        spill_idx       = '0;
        old_val         = '0;

        if (conflict_now) st_d.aborted = 1'b1;

        if (req_valid) begin
            case (op)
                OP_LOAD: begin
                    if (r_xa_hit) begin
                        st_d.resp_ok   = 1'b1;
                        st_d.resp_data = st_q.line[r_xa_idx].data;
                    end else if (r_nm_hit) begin
                        st_d.resp_ok              = 1'b1;
                        st_d.resp_data            = st_q.line[r_nm_idx].data;
                        st_d.line[r_nm_idx].rd    = 1'b1;
                    end else if (v_a_found) begin
                        st_d.line[v_a_idx] = '{tag: TAG_NORMAL, msi: MSI_S, rd: 1'b1,
                                               addr: req_addr, data: mem_rdata};
                        st_d.resp_ok   = 1'b1;
                        st_d.resp_data = mem_rdata;
                        spill          = v_a_dirty;
                        spill_idx      = v_a_idx;
                    end else begin
                        st_d.overflow = 1'b1;
                    end
                end
                OP_LOAD_EXCL, OP_STORE: begin
                    if (r_xa_hit) begin
                        st_d.resp_ok   = 1'b1;
                        st_d.resp_data = st_q.line[r_xa_idx].data;
                        if (op == OP_STORE) st_d.line[r_xa_idx].data = req_wdata;
                    end else if (r_nm_hit) begin
                        if (v_a_found) begin
                            old_val                   = st_q.line[r_nm_idx].data;
                            st_d.line[r_nm_idx].tag   = TAG_XCOMMIT;
                            st_d.line[v_a_idx] = '{tag: TAG_XABORT, msi: MSI_M, rd: 1'b0, addr: req_addr,
                                                   data: (op == OP_STORE) ? req_wdata : old_val};
                            st_d.resp_ok   = 1'b1;
                            st_d.resp_data = old_val;
                            spill          = v_a_dirty;
                            spill_idx      = v_a_idx;
                        end else begin
                            st_d.overflow = 1'b1;
                        end
                    end else if (v_a_found && v_b_found && !(v_a_dirty && v_b_dirty)) begin
                        st_d.line[v_a_idx] = '{tag: TAG_XCOMMIT, msi: MSI_S, rd: 1'b0,
                                               addr: req_addr, data: mem_rdata};
                        st_d.line[v_b_idx] = '{tag: TAG_XABORT, msi: MSI_M, rd: 1'b0, addr: req_addr,
                                               data: (op == OP_STORE) ? req_wdata : mem_rdata};
                        st_d.resp_ok   = 1'b1;
                        st_d.resp_data = mem_rdata;
                        spill          = v_a_dirty || v_b_dirty;
                        spill_idx      = v_a_dirty ? v_a_idx : v_b_idx;
                    end else begin
                        st_d.overflow = 1'b1;
                    end
                end
                OP_COMMIT: begin
                    resolve      = 1'b1;
                    commit_ok    = !abort_now;
                    st_d.resp_ok = !abort_now;
                    st_d.aborted = 1'b0;
                end
                OP_ABORT: begin
                    resolve      = 1'b1;
                    st_d.resp_ok = 1'b1;
                    st_d.aborted = 1'b0;
                end
                OP_VALIDATE: st_d.resp_ok = !abort_now;
                default: ;
            endcase
        end

        if (st_d.overflow) st_d.aborted = 1'b1;

        if (spill) begin
            st_d.wb_valid = 1'b1;
            st_d.wb_addr  = st_q.line[spill_idx].addr;
            st_d.wb_data  = st_q.line[spill_idx].data;
        end

        if (resolve) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.line[i].rd = 1'b0;
                if (st_q.line[i].tag == TAG_XCOMMIT)
                    st_d.line[i].tag = commit_ok ? TAG_EMPTY : TAG_NORMAL;
                else if (st_q.line[i].tag == TAG_XABORT)
                    st_d.line[i].tag = commit_ok ? TAG_NORMAL : TAG_EMPTY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.resp_valid;
    assign resp_ok    = st_q.resp_ok;
    assign resp_data  = st_q.resp_data;
    assign overflow   = st_q.overflow;
    assign wb_valid   = st_q.wb_valid;
    assign wb_addr    = st_q.wb_addr;
    assign wb_data    = st_q.wb_data;
endmodule

// File: rtl/txc_checker.sv
module txc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       snp_valid,
    input logic       resp_valid,
    input logic       resp_ok,
    input logic       overflow,
    input logic       wb_valid
);
    p_resp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !overflow && !wb_valid));

    p_no_overflow_on_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (resp_valid && !resp_ok));

    p_wb_from_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(req_valid) && ($past(req_op) <= 3'd2)));

    p_abort_always_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> resp_ok);

    p_commit_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) ##1 (req_valid && req_op == 3'd5 && !snp_valid) |=> resp_ok);
endmodule

bind txn_line_cache txc_checker u_txc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .snp_valid(snp_valid), .resp_valid(resp_valid), .resp_ok(resp_ok),
    .overflow(overflow), .wb_valid(wb_valid)
);

// File: tb/txn_line_cache_bench.sv
module txn_line_cache_bench;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              snp_valid = 1'b0;
    logic              snp_is_write = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              resp_valid, resp_ok, overflow, wb_valid;
    logic [DATA_W-1:0] resp_data, wb_data;
    logic [ADDR_W-1:0] wb_addr;

    logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_raddr];

    txn_line_cache #(.ENTRIES(4), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_txn_line_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_is_write(snp_is_write),
        .snp_addr(snp_addr), .resp_valid(resp_valid), .resp_ok(resp_ok),
        .resp_data(resp_data), .overflow(overflow), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    localparam logic [2:0] LT = 3'd0, LX = 3'd1, ST = 3'd2, CM = 3'd3, AB = 3'd4, VA = 3'd5;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic        snv;
        logic        snw;
        logic [7:0]  sna;
        logic        exp_ok;
        logic        chk_data;
        logic [15:0] exp_data;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{4'd8,  VA, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R8 idle validate
        '{4'd2,  LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1010}, // R2 miss fill
        '{4'd2,  LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1010}, // R2 hit
        '{4'd3,  ST, 8'h20, 16'hAAAA, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R3 store miss
        '{4'd3,  LT, 8'h20, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'hAAAA}, // R3 sees store
        '{4'd4,  CM, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R4 commit
        '{4'd4,  LT, 8'h20, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'hAAAA}, // R4 committed data
        '{4'd3,  ST, 8'h10, 16'h5555, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R3 store on hit
        '{4'd3,  LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h5555}, // R3
        '{4'd5,  AB, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R5 abort
        '{4'd5,  LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1010}, // R5 old value back
        '{4'd12, LX, 8'h30, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1030}, // R12 exclusive load
        '{4'd12, VA, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 16'h0000}, // R12 remote read
        '{4'd6,  CM, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000}, // R6 commit fails
        '{4'd6,  LT, 8'h30, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1030}, // R6 rolled back
        '{4'd8,  VA, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R8 flag cleared
        '{4'd7,  LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1010}, // R7 read set
        '{4'd7,  VA, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h10, 1'b1, 1'b0, 16'h0000}, // R7 read-read ok
        '{4'd7,  VA, 8'h00, 16'h0000, 1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 16'h0000}, // R7 remote write
        '{4'd8,  AB, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0000}, // R8 abort clears
        '{4'd11, LT, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 16'h1010}, // R11 setup
        '{4'd11, CM, 8'h00, 16'h0000, 1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 16'h0000}, // R11 same cycle
        '{4'd8,  CM, 8'h00, 16'h0000, 1'b1, 1'b1, 8'h40, 1'b1, 1'b0, 16'h0000}  // R8 miss probe
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic [2:0] op, input logic [7:0] addr, input logic [15:0] wd,
                         input logic snv, input logic snw, input logic [7:0] sna);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        snp_valid = snv; snp_is_write = snw; snp_addr = sna;
        @(negedge clk);
        req_valid = 1'b0; snp_valid = 1'b0;
        if (wb_valid) mem[wb_addr] = wb_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 resp_valid in reset", {31'd0, resp_valid}, 32'd0);
        check("R1 overflow in reset", {31'd0, overflow}, 32'd0);
        check("R1 wb_valid in reset", {31'd0, wb_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 16'h1000 + 16'(i);
        @(negedge clk);
        do_reset();

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            apply(VECS[v].op, VECS[v].addr, VECS[v].wdata, VECS[v].snv, VECS[v].snw, VECS[v].sna);
            check({tag, " resp_valid"}, {31'd0, resp_valid}, 32'd1);
            check({tag, " resp_ok"}, {31'd0, resp_ok}, {31'd0, VECS[v].exp_ok});
            if (VECS[v].chk_data) check({tag, " data"}, {16'd0, resp_data}, {16'd0, VECS[v].exp_data});
            if (VECS[v].op == ST) check({tag, " R3 no write-back"}, {31'd0, wb_valid}, 32'd0);
        end
        check("R4 memory untouched by commit", {16'd0, mem[8'h20]}, 32'h1020);

        // R1: reset empties the cache; line 0x20 held 0xAAAA before
        @(negedge clk);
        do_reset();
        apply(VA, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R1 validate after reset", {31'd0, resp_ok}, 32'd1);
        apply(LT, 8'h20, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R1 load after reset", {16'd0, resp_data}, 32'h1020);
        apply(LT, 8'h20, 16'h0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        check("R2 no response when idle", {31'd0, resp_valid}, 32'd0);

        // R9: four read-set lines fill the cache, a fifth overflows
        do_reset();
        for (int a = 1; a <= 4; a++) apply(LT, 8'(a), 16'h0, 1'b0, 1'b0, 8'h00);
        apply(LT, 8'h05, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R9 overflow raised", {30'd0, overflow, resp_ok}, 32'd2);
        apply(VA, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R9 transaction aborted", {31'd0, resp_ok}, 32'd0);
        apply(AB, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);

        // R10 / R13: dirty eviction order and the single write-back lane
        do_reset();
        for (int a = 1; a <= 3; a++) begin
            apply(ST, 8'(a), 16'(a * 16'h0101), 1'b0, 1'b0, 8'h00);
            apply(CM, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        end
        apply(ST, 8'h04, 16'h0404, 1'b0, 1'b0, 8'h00);
        check("R10 write-back valid", {31'd0, wb_valid}, 32'd1);
        check("R10 write-back address", {24'd0, wb_addr}, 32'h01);
        check("R10 write-back data", {16'd0, wb_data}, 32'h0101);
        apply(ST, 8'h05, 16'h0505, 1'b0, 1'b0, 8'h00);
        check("R13 two dirty victims overflow", {31'd0, overflow}, 32'd1);
        check("R13 no write-back", {31'd0, wb_valid}, 32'd0);
        apply(AB, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        apply(LT, 8'h04, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R5 abort restores line 4", {16'd0, resp_data}, 32'h1004);
        apply(LT, 8'h01, 16'h0, 1'b0, 1'b0, 8'h00);
        check("R10 written-back value refetched", {16'd0, resp_data}, 32'h0101);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule